// File: doc/BRIEF.md
# Indexed address-port NVRAM bridge

This block lets a host reach a byte-wide non-volatile memory of up to 64 KiB through a four-byte I/O window. The host builds a 16-bit pointer by writing its two halves to two separate port offsets. It then moves bytes through a single data offset. Every access is one byte wide. The memory sits outside the bridge, behind a synchronous RAM port that takes one cycle to return read data.

Two 16-byte windows of the address space can be protected. Each protection bit is flipped by a one-cycle request on its own input. While a window is protected, stores to it are dropped and loads from it return 0xFF. Addresses at or above the configured memory size are handled the same way. After each data store, the pointer falls back to zero whether or not the store reached memory. A data load leaves the pointer unchanged.

Top module: `nvram_index_bridge`

## Requirements
- R1: A port write at offset 0 loads io_wdata into bits 7:0 of the pointer and leaves bits 15:8 unchanged.
- R2: A port write at offset 1 loads io_wdata into bits 15:8 of the pointer and leaves bits 7:0 unchanged.
- R3: A port write at offset 3 stores io_wdata at the pointed address (when allowed), and the pointer becomes 0x0000 on the same clock edge, even when the store was dropped.
- R4: A port read at offset 3 raises io_rvalid in the next cycle, with io_rdata holding the byte at the pointer. The pointer is unchanged afterwards.
- R5: Lock bit 0 covers addresses 0x20 to 0x2F and lock bit 1 covers 0x30 to 0x3F. While a bit is set, stores to its window do not reach the RAM and loads from it return 0xFF. Addresses 0x1F and 0x40 are never covered.
- R6: A one-cycle pulse on lock_flip[i] inverts lock bit i. Both bits may flip in the same cycle.
- R7: Addresses at or above MEM_SIZE never assert ram_we, and loads from them return 0xFF.
- R8: Reads at offsets 0, 1 and 2 return 0xFF one cycle later with io_rvalid set. A write at offset 2 changes neither the pointer nor the memory.
- R9: Reset sets the pointer to 0x0000 and clears both lock bits.
- R10: An allowed store drives ram_we, ram_addr (the low bits of the pointer) and ram_wdata in the same cycle as the port strobe. An allowed load drives ram_re in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_off | input | 2 | Port offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| io_wr | input | 1 | Port write strobe, one cycle per byte |
| io_rd | input | 1 | Port read strobe, one cycle per byte |
| io_wdata | input | 8 | Port write byte |
| io_rdata | output | 8 | Port read byte, valid while io_rvalid is high |
| io_rvalid | output | 1 | High in the cycle after a read strobe |
| lock_flip | input | NUM_LOCKS | One-cycle request that inverts the matching lock bit |
| ram_addr | output | AW | RAM address (low bits of the pointer) |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after ram_re |

## Verification
The bench builds the bridge with MEM_SIZE set to 128, so AW is 7. With this size, any pointer whose high byte is nonzero is out of range. The high-byte checks for R2 therefore show up as 0xFF reads. The RAM address is truncated, so address 0x80 would alias onto address 0. A store that wrongly got through at or above the size would then corrupt the byte at 0, and this is visible. The default lock windows at 0x20 and 0x30 fall inside this small memory, so each window edge and its neighbour outside the window can be probed.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

   typedef enum logic [1:0] {
      OFF_PTR_LO = 2'd0,
      OFF_PTR_HI = 2'd1,
      OFF_SPARE  = 2'd2,
      OFF_DATA   = 2'd3
   } nvb_off_e;

   localparam int unsigned PTR_W     = 16;
   localparam logic [7:0]  NVB_BLANK = 8'hFF;

endpackage

// File: rtl/nvb_pointer.sv
module nvb_pointer
   import nvb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic             clr,
   input  logic [7:0]       din,
   output logic [PTR_W-1:0] ptr
);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr) begin
         ptr_q <= '0;
      end else begin
         if (ld_lo) ptr_q[7:0]  <= din;
         if (ld_hi) ptr_q[15:8] <= din;
      end
   end

   assign ptr = ptr_q;

   // R1: a low load keeps the high half
   p_low_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_lo && !ld_hi && !clr) |=> (ptr[7:0] == $past(din)) && (ptr[15:8] == $past(ptr[15:8])));

   // R2: a high load keeps the low half
   p_high_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo && !clr) |=> (ptr[15:8] == $past(din)) && (ptr[7:0] == $past(ptr[7:0])));

   // R3: a data store returns the pointer to zero
   p_clear_after_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0));

endmodule

// File: rtl/nvb_guard.sv
module nvb_guard
   import nvb_pkg::*;
#(
   parameter int unsigned MEM_SIZE  = 8192,
   parameter int unsigned NUM_LOCKS = 2,
   parameter int unsigned LOCK_BASE = 32'h20,
   parameter int unsigned LOCK_SPAN = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOCKS-1:0] flip,
   input  logic [PTR_W-1:0]     addr,
   output logic                 allow
);

   localparam int unsigned MAX_SPACE = 1 << PTR_W;

   logic [NUM_LOCKS-1:0] lock_q;
   logic [NUM_LOCKS-1:0] hit;
   logic                 in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= lock_q ^ flip;
   end

   for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_win
      localparam int unsigned LO = LOCK_BASE + g * LOCK_SPAN;
      localparam int unsigned HI = LO + LOCK_SPAN;
      assign hit[g] = (32'(addr) >= LO) && (32'(addr) < HI);

      // R6: each request inverts exactly its own bit
      p_flip_inverts_r6: assert property (@(posedge clk) disable iff (!rst_n)
         flip[g] |=> (lock_q[g] != $past(lock_q[g])));
      p_hold_without_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !flip[g] |=> $stable(lock_q[g]));
      // R5: a set lock over this window denies access
      p_locked_denies_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_q[g] && (32'(addr) >= LO) && (32'(addr) < HI)) |-> !allow);
   end

   if (MEM_SIZE >= MAX_SPACE) begin : g_full_space
      assign in_range = 1'b1;
   end else begin : g_bounded
      assign in_range = 32'(addr) < MEM_SIZE;
   end

   assign allow = in_range && !(|(hit & lock_q));

endmodule

// File: rtl/nvb_rdpath.sv
module nvb_rdpath
   import nvb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_any,
   input  logic       rd_pass,
   input  logic [7:0] ram_rdata,
   output logic [7:0] io_rdata,
   output logic       io_rvalid
);

   logic valid_q;
   logic pass_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         valid_q <= rd_any;
         pass_q  <= rd_any && rd_pass;
      end
   end

   assign io_rvalid = valid_q;
   assign io_rdata  = pass_q ? ram_rdata : NVB_BLANK;

endmodule

// File: rtl/nvram_index_bridge.sv
module nvram_index_bridge
   import nvb_pkg::*;
#(
   parameter int unsigned MEM_SIZE  = 8192,
   parameter int unsigned NUM_LOCKS = 2,
   parameter int unsigned LOCK_BASE = 32'h20,
   parameter int unsigned LOCK_SPAN = 16,
   localparam int unsigned AW = (MEM_SIZE > 2) ? $clog2(MEM_SIZE) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           io_off,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [7:0]           io_wdata,
   output logic [7:0]           io_rdata,
   output logic                 io_rvalid,
   input  logic [NUM_LOCKS-1:0] lock_flip,
   output logic [AW-1:0]        ram_addr,
   output logic                 ram_we,
   output logic                 ram_re,
   output logic [7:0]           ram_wdata,
   input  logic [7:0]           ram_rdata
);

   if (MEM_SIZE < 2 || MEM_SIZE > (1 << PTR_W)) begin : g_bad_size
      $error("MEM_SIZE must lie in 2..65536");
   end
   if (NUM_LOCKS < 1) begin : g_bad_locks
      $error("NUM_LOCKS must be at least 1");
   end
   if (LOCK_SPAN < 1 || (LOCK_BASE + NUM_LOCKS * LOCK_SPAN) > (1 << PTR_W)) begin : g_bad_win
      $error("lock windows must fit in the 16-bit space");
   end

   logic [PTR_W-1:0] ptr;
   logic             allow;
   logic             rd_any;
   logic             data_wr;
   logic             data_rd;

   assign rd_any  = io_rd && !io_wr;
   assign data_wr = io_wr && (io_off == OFF_DATA);
   assign data_rd = rd_any && (io_off == OFF_DATA);

   nvb_pointer u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (io_wr && (io_off == OFF_PTR_LO)),
      .ld_hi (io_wr && (io_off == OFF_PTR_HI)),
      .clr   (data_wr),
      .din   (io_wdata),
      .ptr   (ptr)
   );

   nvb_guard #(
      .MEM_SIZE  (MEM_SIZE),
      .NUM_LOCKS (NUM_LOCKS),
      .LOCK_BASE (LOCK_BASE),
      .LOCK_SPAN (LOCK_SPAN)
   ) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (lock_flip),
      .addr  (ptr),
      .allow (allow)
   );

   assign ram_we    = data_wr && allow;
   assign ram_re    = data_rd && allow;
   assign ram_addr  = ptr[AW-1:0];
   assign ram_wdata = io_wdata;

   nvb_rdpath u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_any    (rd_any),
      .rd_pass   (ram_re),
      .ram_rdata (ram_rdata),
      .io_rdata  (io_rdata),
      .io_rvalid (io_rvalid)
   );

   // R4: a read strobe is answered in the next cycle
   p_read_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> io_rvalid);

   // R4: a data read leaves the pointer alone
   p_read_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> $stable(ptr));

   // R7: no RAM traffic outside the memory
   p_no_oob_traffic_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_re) |-> (32'(ptr) < MEM_SIZE));

   // R8: control offsets read back as blank
   p_ctrl_read_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && (io_off != OFF_DATA)) |=> (io_rdata == NVB_BLANK));

   // R8: spare offset write leaves the pointer alone
   p_spare_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && (io_off == OFF_SPARE)) |=> $stable(ptr));

   // R10: RAM write only in a data-write cycle
   p_we_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (io_wr && (io_off == OFF_DATA) && !ram_re));

endmodule

// File: tb/sim_nvram_index_bridge.sv
module sim_nvram_index_bridge;

   localparam int unsigned MEM_SIZE = 128;
   localparam int unsigned AW       = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] io_off = '0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic       io_rvalid;
   logic [1:0] lock_flip = '0;
   logic [AW-1:0] ram_addr;
   logic       ram_we;
   logic       ram_re;
   logic [7:0] ram_wdata;
   logic [7:0] ram_rdata = '0;

   logic [7:0] mem [0:MEM_SIZE-1];

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   nvram_index_bridge #(.MEM_SIZE(MEM_SIZE)) u0 (
      .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
      .lock_flip(lock_flip), .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_addr];
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic port_wr(input logic [1:0] off, input logic [7:0] d, output logic we_seen,
                          output logic [AW-1:0] addr_seen, output logic [7:0] wd_seen);
      @(negedge clk);
      io_off = off; io_wdata = d; io_wr = 1'b1;
      #1;
      we_seen = ram_we; addr_seen = ram_addr; wd_seen = ram_wdata;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic pw(input logic [1:0] off, input logic [7:0] d);
      logic w; logic [AW-1:0] a; logic [7:0] x;
      port_wr(off, d, w, a, x);
   endtask

   task automatic port_rd(input logic [1:0] off, output logic [7:0] d);
      @(negedge clk);
      io_off = off; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      check("R4 rvalid", 16'(io_rvalid), 16'h1);
      d = io_rdata;
   endtask

   task automatic set_ptr(input logic [15:0] a);
      pw(2'd0, a[7:0]);
      pw(2'd1, a[15:8]);
   endtask

   task automatic mem_wr(input logic [15:0] a, input logic [7:0] d, input logic exp_we, input string req);
      logic w; logic [AW-1:0] ad; logic [7:0] x;
      set_ptr(a);
      port_wr(2'd3, d, w, ad, x);
      check(req, 16'(w), 16'(exp_we));
   endtask

   task automatic mem_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
      logic [7:0] d;
      set_ptr(a);
      port_rd(2'd3, d);
      check(req, 16'(d), 16'(exp));
   endtask

   task automatic flip(input logic [1:0] v);
      @(negedge clk);
      lock_flip = v;
      @(negedge clk);
      lock_flip = '0;
   endtask

   task automatic t_reset_state();
      logic w; logic [AW-1:0] a; logic [7:0] x;
      check("R9 rvalid low after reset", 16'(io_rvalid), 16'h0);
      port_wr(2'd3, 8'h5A, w, a, x);   // pointer is 0 after reset
      check("R9 pointer zero after reset", 16'(a), 16'h0);
      check("R10 ram_we with strobe", 16'(w), 16'h1);
      check("R10 ram_wdata", 16'(x), 16'h5A);
   endtask

   task automatic t_pointer();
      logic [7:0] d;
      mem_wr(16'h0040, 8'h11, 1'b1, "R10 store 0x40");
      mem_wr(16'h0041, 8'h22, 1'b1, "R10 store 0x41");
      pw(2'd1, 8'h00); pw(2'd0, 8'h40);
      port_rd(2'd3, d); check("R1 low load", 16'(d), 16'h11);
      pw(2'd0, 8'h41);
      port_rd(2'd3, d); check("R1 high byte kept", 16'(d), 16'h22);
      port_rd(2'd3, d); check("R4 pointer unchanged by read", 16'(d), 16'h22);
      pw(2'd1, 8'h01);
      port_rd(2'd3, d); check("R2 high load to 0x0141 out of range", 16'(d), 16'hFF);
      pw(2'd1, 8'h00);
      port_rd(2'd3, d); check("R2 low byte kept", 16'(d), 16'h22);
   endtask

   task automatic t_clear();
      logic [7:0] d;
      mem_wr(16'h0010, 8'h77, 1'b1, "R10 store 0x10");
      port_rd(2'd3, d); check("R3 pointer cleared after store", 16'(d), 16'h5A);
      mem_rd(16'h0010, 8'h77, "R4 read 0x10");
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      set_ptr(16'h0041);
      port_rd(2'd0, d); check("R8 offset0 read", 16'(d), 16'hFF);
      port_rd(2'd1, d); check("R8 offset1 read", 16'(d), 16'hFF);
      port_rd(2'd2, d); check("R8 offset2 read", 16'(d), 16'hFF);
      pw(2'd2, 8'h00);
      port_rd(2'd3, d); check("R8 offset2 write ignored", 16'(d), 16'h22);
   endtask

   task automatic t_locks();
      logic [7:0] d;
      mem_wr(16'h0025, 8'h33, 1'b1, "R5 prefill 0x25");
      mem_wr(16'h0030, 8'h35, 1'b1, "R5 prefill 0x30");
      mem_wr(16'h001F, 8'h36, 1'b1, "R5 prefill 0x1F");
      mem_wr(16'h003F, 8'h37, 1'b1, "R5 prefill 0x3F");
      flip(2'b01);
      mem_rd(16'h0025, 8'hFF, "R5 lock0 read 0x25");
      mem_rd(16'h002F, 8'hFF, "R5 lock0 read 0x2F");
      mem_rd(16'h0030, 8'h35, "R5 0x30 open under lock0");
      mem_rd(16'h001F, 8'h36, "R5 0x1F never covered");
      mem_wr(16'h0025, 8'h44, 1'b0, "R5 locked store blocked");
      port_rd(2'd3, d); check("R3 pointer cleared after blocked store", 16'(d), 16'h5A);
      flip(2'b01);
      mem_rd(16'h0025, 8'h33, "R6 second flip unlocks, store was dropped");
      flip(2'b10);
      mem_rd(16'h0030, 8'hFF, "R5 lock1 read 0x30");
      mem_rd(16'h003F, 8'hFF, "R5 lock1 read 0x3F");
      mem_rd(16'h0040, 8'h11, "R5 0x40 never covered");
      mem_rd(16'h0025, 8'h33, "R6 lock0 untouched by lock1 flip");
      flip(2'b11);
      mem_rd(16'h0025, 8'hFF, "R6 dual flip sets lock0");
      mem_rd(16'h0030, 8'h35, "R6 dual flip clears lock1");
      do_reset();
      mem_rd(16'h0025, 8'h33, "R9 locks cleared by reset");
   endtask

   task automatic t_range();
      mem_wr(16'h007F, 8'h66, 1'b1, "R7 last address stored");
      mem_wr(16'h0080, 8'h99, 1'b0, "R7 store at MEM_SIZE blocked");
      mem_rd(16'h0000, 8'h5A, "R7 no alias onto 0");
      mem_rd(16'h0080, 8'hFF, "R7 read at MEM_SIZE");
      mem_rd(16'h007F, 8'h66, "R7 read last address");
      mem_rd(16'hFFFF, 8'hFF, "R7 read top of space");
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_pointer();
      t_clear();
      t_ctrl();
      t_locks();
      t_range();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule